// File: doc/BRIEF.md
# Spill Synchronization Gate with Bypass Control

This block decides when the experiment may ask the accelerator for a spill. It also times the per-system triggers that follow the machine start. Four subsystem ready flags feed it: data acquisition, RF, target and machine control. Once all four are true it raises a spill request. The request is held until a rising edge on the machine-start input validates it. That validated start then launches three independent programmable countdowns. Each countdown ends in a single-cycle pulse: the target trigger, the RF trigger and the dead-time gate.

A central bypass register controls test running. Each of its low four bits forces one ready flag true. The fifth bit swaps the machine-start source for a free-running once-per-second tick, so the chain can run without beam. At start of run the block inspects the bypass register. If any bit is set, it raises a warning flag that stays up until it is acknowledged. All inputs are taken as synchronous to `clk`. The reset is synchronous and active high.

Top module: `spill_sync_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, spill_req, target_trig, rf_trig, dt_gate and bypass_warn are low and bypass_q reads 0.
- R2: spill_req rises one clock after the four effective ready flags are all true while the block is armed, and falls one clock after any effective ready flag goes false.
- R3: bypass_q bit 0 forces DAQ ready, bit 1 forces RF ready, bit 2 forces target ready and bit 3 forces machine-control ready to true, whatever the raw input.
- R4: A start edge seen while spill_req is high validates the request, and spill_req falls on that same clock edge. The request is not raised again until at least one effective ready flag has been false for a cycle.
- R5: A start edge seen while spill_req is low produces no trigger pulse.
- R6: With bypass_q bit 4 set, only a rising edge of tick_1hz acts as the start and mach_start is ignored. With bit 4 clear, tick_1hz is ignored.
- R7: Each of target_trig, rf_trig and dt_gate is a one-cycle pulse. It rises D+1 clocks after the clock edge on which spill_req falls by validation, where D is the value of its own delay port at validation, so D=0 gives a pulse on the next edge.
- R8: bypass_q takes cfg_wdata only on a clock edge with cfg_we high, and otherwise keeps its value.
- R9: A run_start pulse while bypass_q is non-zero sets bypass_warn. The flag stays set until a warn_ack, and setting wins over a simultaneous acknowledge. A run_start pulse with bypass_q zero leaves bypass_warn clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| daq_ready | input | 1 | Data acquisition ready flag |
| rf_ready | input | 1 | RF system ready flag |
| target_ready | input | 1 | Target system ready flag |
| mcm_ready | input | 1 | Machine-control ready flag |
| mach_start | input | 1 | Gated machine start from the accelerator |
| tick_1hz | input | 1 | Free-running once-per-second clock |
| cfg_we | input | 1 | Bypass register write enable |
| cfg_wdata | input | 5 | Bypass register write data |
| run_start | input | 1 | Start-of-run pulse |
| warn_ack | input | 1 | Clears the bypass warning |
| target_delay | input | DLY_W | Countdown for the target trigger |
| rf_delay | input | DLY_W | Countdown for the RF trigger |
| dt_delay | input | DLY_W | Countdown for the dead-time gate |
| spill_req | output | 1 | Spill request to the accelerator |
| target_trig | output | 1 | Target trigger pulse |
| rf_trig | output | 1 | RF trigger pulse |
| dt_gate | output | 1 | Dead-time gate pulse |
| bypass_warn | output | 1 | Sticky bypass-active warning |
| bypass_q | output | 5 | Current bypass register contents |

## Verification
The hardest state to reach from the ports is the spent state: a validated request with every ready flag still true. In that state the block must refuse to re-request. To get there, the bench holds all readies high through a full firing, checks that spill_req stays low, and then drops and restores a single flag to re-arm the block. The start-source swap is just as indirect. It is exercised by sending a mach_start edge and a tick edge against one pending request, both with and without the substitution bit, and by confirming that only the selected source produces triggers. The three countdowns are loaded with distinct values, including zero, so that their pulses land on different cycles.

// File: rtl/spill_sync_pkg.sv
package spill_sync_pkg;

    localparam int BYP_W    = 5;
    localparam int NUM_TRIG = 3;

    localparam int TRG_TARGET = 0;
    localparam int TRG_RF     = 1;
    localparam int TRG_DTGATE = 2;

    // bit 0 daq, bit 1 rf, bit 2 target, bit 3 machine control, bit 4 start-source swap
    typedef struct packed {
        logic clk_sub;
        logic mcm;
        logic tgt;
        logic rf;
        logic daq;
    } bypass_t;

    typedef struct packed {
        logic mcm;
        logic tgt;
        logic rf;
        logic daq;
    } ready_t;

    typedef enum logic [1:0] {
        ARB_ARMED   = 2'd0,
        ARB_PENDING = 2'd1,
        ARB_SPENT   = 2'd2
    } arb_state_e;

    function automatic ready_t force_ready(ready_t raw, bypass_t byp);
        ready_t r;
        r.daq = raw.daq | byp.daq;
        r.rf  = raw.rf  | byp.rf;
        r.tgt = raw.tgt | byp.tgt;
        r.mcm = raw.mcm | byp.mcm;
        return r;
    endfunction

    function automatic logic all_set(ready_t r);
        return &r;
    endfunction

endpackage

// File: rtl/spill_edge_det.sv
module spill_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sig_in;
    end

    assign rise = sig_in & ~prev;
endmodule

// File: rtl/spill_arbiter.sv
module spill_arbiter
    import spill_sync_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ready_t rdy_eff,
    input  logic   start_rise,
    output logic   spill_req,
    output logic   launch
);
    arb_state_e st, st_n;
    logic       all_rdy;

    assign all_rdy = all_set(rdy_eff);
    assign launch  = start_rise && (st == ARB_PENDING);

    always_comb begin
        st_n = st;
        unique case (st)
            ARB_ARMED:   if (all_rdy) st_n = ARB_PENDING;
            ARB_PENDING: begin
                if (launch)        st_n = ARB_SPENT;
                else if (!all_rdy) st_n = ARB_ARMED;
            end
            ARB_SPENT:   if (!all_rdy) st_n = ARB_ARMED;
            default:     st_n = ARB_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ARB_ARMED;
        else     st <= st_n;
    end

    assign spill_req = (st == ARB_PENDING);

    // R2
    req_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_req) |-> $past(all_rdy));

    // R4
    launch_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !spill_req);
endmodule

// File: rtl/spill_trig_delay.sv
module spill_trig_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic [W-1:0] dly,
    output logic         pulse
);
    logic         busy;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (launch) begin
                busy <= 1'b1;
                cnt  <= dly;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy  <= 1'b0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7
    pulse_after_count_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(busy));
endmodule

// File: rtl/spill_bypass_reg.sv
module spill_bypass_reg
    import spill_sync_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  bypass_t wdata,
    input  logic    run_start,
    input  logic    ack,
    output bypass_t byp_q,
    output logic    warn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= '0;
            warn  <= 1'b0;
        end else begin
            if (we) byp_q <= wdata;
            if (run_start && (|byp_q)) warn <= 1'b1;
            else if (ack)              warn <= 1'b0;
        end
    end

    // R8
    bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(byp_q));

    // R9
    warn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(warn) |-> ($past(run_start) && ($past(byp_q) != '0)));

    // R9
    warn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (warn && !ack) |=> warn);
endmodule

// File: rtl/spill_sync_gate.sv
module spill_sync_gate
    import spill_sync_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             daq_ready,
    input  logic             rf_ready,
    input  logic             target_ready,
    input  logic             mcm_ready,
    input  logic             mach_start,
    input  logic             tick_1hz,
    input  logic             cfg_we,
    input  logic [BYP_W-1:0] cfg_wdata,
    input  logic             run_start,
    input  logic             warn_ack,
    input  logic [DLY_W-1:0] target_delay,
    input  logic [DLY_W-1:0] rf_delay,
    input  logic [DLY_W-1:0] dt_delay,
    output logic             spill_req,
    output logic             target_trig,
    output logic             rf_trig,
    output logic             dt_gate,
    output logic             bypass_warn,
    output logic [BYP_W-1:0] bypass_q
);
    bypass_t              byp;
    ready_t               rdy_raw, rdy_eff;
    logic                 mach_rise, tick_rise, start_rise, launch;
    logic [DLY_W-1:0]     dly_arr [NUM_TRIG];
    logic [NUM_TRIG-1:0]  trig_vec;

    spill_bypass_reg u_breg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (bypass_t'(cfg_wdata)),
        .run_start (run_start),
        .ack       (warn_ack),
        .byp_q     (byp),
        .warn      (bypass_warn)
    );

    assign bypass_q    = byp;
    assign rdy_raw.daq = daq_ready;
    assign rdy_raw.rf  = rf_ready;
    assign rdy_raw.tgt = target_ready;
    assign rdy_raw.mcm = mcm_ready;
    assign rdy_eff     = force_ready(rdy_raw, byp);

    spill_edge_det u_mach_edge (.clk(clk), .rst(rst), .sig_in(mach_start), .rise(mach_rise));
    spill_edge_det u_tick_edge (.clk(clk), .rst(rst), .sig_in(tick_1hz),   .rise(tick_rise));

    assign start_rise = byp.clk_sub ? tick_rise : mach_rise;

    spill_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .rdy_eff    (rdy_eff),
        .start_rise (start_rise),
        .spill_req  (spill_req),
        .launch     (launch)
    );

    assign dly_arr[TRG_TARGET] = target_delay;
    assign dly_arr[TRG_RF]     = rf_delay;
    assign dly_arr[TRG_DTGATE] = dt_delay;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_dly
        spill_trig_delay #(.W(DLY_W)) u_dly (
            .clk    (clk),
            .rst    (rst),
            .launch (launch),
            .dly    (dly_arr[g]),
            .pulse  (trig_vec[g])
        );
    end

    assign target_trig = trig_vec[TRG_TARGET];
    assign rf_trig     = trig_vec[TRG_RF];
    assign dt_gate     = trig_vec[TRG_DTGATE];

    // R6
    src_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (byp.clk_sub && !tick_rise) |-> !launch);

    // R6
    src_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (!byp.clk_sub && !mach_rise) |-> !launch);
endmodule

// File: tb/spill_sync_gate_test.sv
module spill_sync_gate_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          daq_ready, rf_ready, target_ready, mcm_ready;
    logic          mach_start, tick_1hz, cfg_we, run_start, warn_ack;
    logic [4:0]    cfg_wdata;
    logic [DW-1:0] target_delay, rf_delay, dt_delay;
    logic          spill_req, target_trig, rf_trig, dt_gate, bypass_warn;
    logic [4:0]    bypass_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    spill_sync_gate #(.DLY_W(DW)) uut (
        .clk(clk), .rst(rst),
        .daq_ready(daq_ready), .rf_ready(rf_ready),
        .target_ready(target_ready), .mcm_ready(mcm_ready),
        .mach_start(mach_start), .tick_1hz(tick_1hz),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .run_start(run_start), .warn_ack(warn_ack),
        .target_delay(target_delay), .rf_delay(rf_delay), .dt_delay(dt_delay),
        .spill_req(spill_req), .target_trig(target_trig), .rf_trig(rf_trig),
        .dt_gate(dt_gate), .bypass_warn(bypass_warn), .bypass_q(bypass_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_rdy(input logic [3:0] r);
        {mcm_ready, target_ready, rf_ready, daq_ready} = r;
    endtask

    task automatic write_byp(input logic [4:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Pulses the chosen start source and watches the three triggers.
    task automatic fire(input bit use_tick, input bit expect_fire,
                        input int d0, input int d1, input int d2, input string req);
        int first [3];
        int cnt   [3];
        logic [2:0] t;
        target_delay = DW'(d0); rf_delay = DW'(d1); dt_delay = DW'(d2);
        for (int i = 0; i < 3; i++) begin first[i] = -1; cnt[i] = 0; end
        if (use_tick) tick_1hz = 1'b1; else mach_start = 1'b1;
        step();
        if (expect_fire) check(spill_req == 1'b0, "R4", int'(spill_req), 0);
        mach_start = 1'b0; tick_1hz = 1'b0;
        for (int k = 0; k < 40; k++) begin
            t = {dt_gate, rf_trig, target_trig};
            for (int i = 0; i < 3; i++)
                if (t[i]) begin
                    cnt[i]++;
                    if (first[i] < 0) first[i] = k;
                end
            step();
        end
        if (expect_fire) begin
            check(first[0] == d0 + 1 && cnt[0] == 1, "R7", first[0], d0 + 1);
            check(first[1] == d1 + 1 && cnt[1] == 1, "R7", first[1], d1 + 1);
            check(first[2] == d2 + 1 && cnt[2] == 1, "R7", first[2], d2 + 1);
        end else begin
            check(cnt[0] + cnt[1] + cnt[2] == 0, req, cnt[0] + cnt[1] + cnt[2], 0);
        end
    endtask

    task automatic t_reset();
        // R1
        check(spill_req == 0 && target_trig == 0 && rf_trig == 0 && dt_gate == 0,
              "R1", int'({spill_req, target_trig, rf_trig, dt_gate}), 0);
        check(bypass_warn == 0 && bypass_q == 0, "R1", int'({bypass_warn, bypass_q}), 0);
    endtask

    task automatic t_ready();
        set_rdy(4'b0111); step(); step();
        check(spill_req == 0, "R2", int'(spill_req), 0);
        set_rdy(4'b1110); step(); step();
        check(spill_req == 0, "R2", int'(spill_req), 0);
        set_rdy(4'b1111); step();
        check(spill_req == 1, "R2", int'(spill_req), 1);
        set_rdy(4'b1011); step();
        check(spill_req == 0, "R2", int'(spill_req), 0);
        set_rdy(4'b0000); step();
    endtask

    task automatic t_force();
        for (int i = 0; i < 4; i++) begin
            write_byp(5'(1 << i));
            set_rdy(4'b1111 & ~4'(1 << i));
            step(); step();
            // R3
            check(spill_req == 1, "R3", i, 1);
            set_rdy(4'b0000);
            write_byp(5'd0);
            step();
            check(spill_req == 0, "R3", int'(spill_req), 0);
        end
    endtask

    task automatic t_fire_rearm();
        set_rdy(4'b1111); step(); step();
        check(spill_req == 1, "R2", int'(spill_req), 1);
        fire(1'b0, 1'b1, 3, 0, 7, "R7");
        // R4: spent, readies still true
        check(spill_req == 0, "R4", int'(spill_req), 0);
        daq_ready = 1'b0; step();
        daq_ready = 1'b1; step();
        check(spill_req == 1, "R4", int'(spill_req), 1);
        fire(1'b0, 1'b1, 12, 5, 1, "R7");
    endtask

    task automatic t_no_pending();
        set_rdy(4'b0000); step(); step();
        fire(1'b0, 1'b0, 2, 2, 2, "R5");
    endtask

    task automatic t_tick_swap();
        set_rdy(4'b1111); step(); step();
        fire(1'b1, 1'b0, 1, 1, 1, "R6");
        check(spill_req == 1, "R6", int'(spill_req), 1);
        write_byp(5'b10000);
        fire(1'b0, 1'b0, 1, 1, 1, "R6");
        check(spill_req == 1, "R6", int'(spill_req), 1);
        fire(1'b1, 1'b1, 2, 4, 6, "R6");
        write_byp(5'd0);
        set_rdy(4'b0000); step();
    endtask

    task automatic t_cfg();
        write_byp(5'b01010); step();
        check(bypass_q == 5'b01010, "R8", int'(bypass_q), 10);
        cfg_wdata = 5'b11111; step(); step();
        check(bypass_q == 5'b01010, "R8", int'(bypass_q), 10);
        write_byp(5'd0); step();
        check(bypass_q == 5'd0, "R8", int'(bypass_q), 0);
    endtask

    task automatic t_warn();
        run_start = 1'b1; step(); run_start = 1'b0; step();
        check(bypass_warn == 0, "R9", int'(bypass_warn), 0);
        write_byp(5'b00100);
        run_start = 1'b1; step(); run_start = 1'b0;
        check(bypass_warn == 1, "R9", int'(bypass_warn), 1);
        step(); step(); step();
        check(bypass_warn == 1, "R9", int'(bypass_warn), 1);
        warn_ack = 1'b1; step(); warn_ack = 1'b0;
        check(bypass_warn == 0, "R9", int'(bypass_warn), 0);
        run_start = 1'b1; warn_ack = 1'b1; step();
        run_start = 1'b0; warn_ack = 1'b0;
        check(bypass_warn == 1, "R9", int'(bypass_warn), 1);
        warn_ack = 1'b1; step(); warn_ack = 1'b0;
        write_byp(5'd0);
    endtask

    initial begin
        rst = 1'b1;
        set_rdy(4'b0000);
        mach_start = 0; tick_1hz = 0; cfg_we = 0; cfg_wdata = 0;
        run_start = 0; warn_ack = 0;
        target_delay = 0; rf_delay = 0; dt_delay = 0;
        step(); step(); step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_ready();
        t_force();
        t_fire_rearm();
        t_no_pending();
        t_tick_swap();
        t_cfg();
        t_warn();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule